// File: doc/BRIEF.md
# Multi-Source Wake-Up Detector

This block ends a low-power suspended state. A suspend-request line puts the device to sleep. The block then watches for the condition that ends the sleep and signals it with a single-cycle wake pulse to a power-state sequencer. A second output gives the cleaned, synchronized suspend level that the sequencer uses to enter sleep.

There are two wake modes:
- **Single-line mode:** the wake event is the suspend line falling.
- **Multi-pin mode:** the suspend line must fall first. After that, a rising edge on any one of eight auxiliary pins wakes the device. An 8-bit enable mask chooses which pins take part.

Every input passes through a two-flop synchronizer. A bypassable glitch filter can clean the suspend line. A global enable makes the block ignore the suspend line completely. The auxiliary pins are also ordinary inputs, so other logic may read them directly.

Top module: `wake_detect`

## Requirements
- R1: After reset, `susp_lvl_o` and `wake_o` are 0.
- R2: When `susp_en_i` is 0, `susp_i` is ignored: `susp_lvl_o` stays 0 and no wake pulse is produced.
- R3: With the filter bypassed (`filt_en_i`=0) and the feature enabled, `susp_lvl_o` follows `susp_i` with a latency of two clock cycles.
- R4: With the filter enabled, `susp_lvl_o` takes a new level only after the synchronized suspend input has held that level for FILT_LEN consecutive samples (default 4), giving a latency of FILT_LEN+2 cycles. A pulse shorter than FILT_LEN cycles is dropped.
- R5: In single-line mode (`multi_en_i`=0), a suspended device produces one wake pulse in the cycle after `susp_lvl_o` falls.
- R6: In multi-pin mode, `susp_lvl_o` falling produces no wake pulse.
- R7: In multi-pin mode, after the suspend level has fallen, a rising edge on pin i with `wake_mask_i[i]`=1 gives a wake pulse three cycles after the edge is driven. Mask bit i governs pin i, so 8'hFF enables all pins and 8'h0F enables pins 3 to 0.
- R8: Rising edges on pins whose mask bit is 0 never produce a wake pulse.
- R9: Pin edges are ignored while the suspend level is high, while the device is awake, and in the same cycle that the suspend level falls.
- R10: Pins are edge-sensed: a pin already high when the suspend level falls does not wake the device.
- R11: `wake_o` lasts exactly one cycle. After it, the device counts as awake until the suspend level rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| susp_en_i | input | 1 | Suspend feature enable |
| multi_en_i | input | 1 | Multi-pin wake mode enable |
| filt_en_i | input | 1 | Route the suspend line through the glitch filter |
| wake_mask_i | input | 8 | Per-pin wake enable, bit i for pin i |
| susp_i | input | 1 | Asynchronous suspend request |
| wake_pins_i | input | 8 | Asynchronous auxiliary wake pins |
| susp_lvl_o | output | 1 | Synchronized, optionally filtered suspend level |
| wake_o | output | 1 | One-cycle wake event |

## Verification
The arming step (the suspend level falling) and a pin edge can land in the same cycle. The bench provokes this by driving both changes on the same clock edge in bypass mode. It expects no wake pulse, because the block is not yet armed when the edge is seen. It then requires a later, separate rising edge on that pin to wake the device three cycles after it is driven. Random trials with random masks and pin choices check that wake pulses appear exactly when the chosen pin's mask bit is set.

// File: rtl/wk_pkg.sv
package wk_pkg;
  typedef enum logic [1:0] {
    ST_AWAKE  = 2'd0,
    ST_ASLEEP = 2'd1,
    ST_ARMED  = 2'd2
  } wk_state_e;
endpackage

// File: rtl/wk_sync.sv
module wk_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/wk_glitch_filter.sv
module wk_glitch_filter #(
  parameter int FILT_LEN = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  localparam int CW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;
  localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

  logic [CW-1:0] cnt_q;
  logic          lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= 1'b0;
    end else if (d_i == lvl_q) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
      lvl_q <= d_i;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign q_o = lvl_q;

  // new level must equal the input sampled on that edge
  assert_filt_follows_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q != $past(lvl_q)) |-> ($past(d_i) == lvl_q));
endmodule

// File: rtl/wk_edge_detect.sv
module wk_edge_detect #(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPINS-1:0] pins_i,
  input  logic [NPINS-1:0] mask_i,
  output logic [NPINS-1:0] rise_o
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= pins_i;
  end

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    assign rise_o[i] = mask_i[i] & pins_i[i] & ~prev_q[i];
  end
endmodule

// File: rtl/wk_fsm.sv
module wk_fsm
  import wk_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_i,
  input  logic             multi_en_i,
  input  logic [NPINS-1:0] rise_i,
  output logic             wake_o
);
  wk_state_e state_q, state_d;
  logic      wake_q, wake_d;

  always_comb begin
    state_d = state_q;
    wake_d  = 1'b0;
    unique case (state_q)
      ST_AWAKE:  if (lvl_i) state_d = ST_ASLEEP;
      ST_ASLEEP: if (!lvl_i) begin
        if (multi_en_i) state_d = ST_ARMED;
        else begin
          state_d = ST_AWAKE;
          wake_d  = 1'b1;
        end
      end
      ST_ARMED: begin
        if (lvl_i) state_d = ST_ASLEEP;
        else if (|rise_i) begin
          state_d = ST_AWAKE;
          wake_d  = 1'b1;
        end
      end
      default: state_d = ST_AWAKE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_AWAKE;
      wake_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= wake_d;
    end
  end

  assign wake_o = wake_q;

  assert_wake_one_cycle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_q |=> !wake_q);
  assert_no_wake_awake_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AWAKE) |=> !wake_q);
  assert_multi_fall_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ASLEEP && multi_en_i) |=> !wake_q);
  assert_masked_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ARMED && rise_i == '0) |=> !wake_q);
endmodule

// File: rtl/wake_detect.sv
module wake_detect #(
  parameter int NPINS    = 8,
  parameter int FILT_LEN = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             susp_en_i,
  input  logic             multi_en_i,
  input  logic             filt_en_i,
  input  logic [NPINS-1:0] wake_mask_i,
  input  logic             susp_i,
  input  logic [NPINS-1:0] wake_pins_i,
  output logic             susp_lvl_o,
  output logic             wake_o
);
  localparam int SW = NPINS + 1;

  logic [SW-1:0]    sync_q;
  logic [NPINS-1:0] pins_s, rise;
  logic             susp_s, filt_lvl, lvl;

  wk_sync #(.W(SW)) u_sync (
    .clk_i, .rst_ni,
    .d_i ({susp_i, wake_pins_i}),
    .q_o (sync_q)
  );

  assign susp_s = sync_q[SW-1];
  assign pins_s = sync_q[NPINS-1:0];

  wk_glitch_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk_i, .rst_ni,
    .d_i (susp_s),
    .q_o (filt_lvl)
  );

  assign lvl        = susp_en_i & (filt_en_i ? filt_lvl : susp_s);
  assign susp_lvl_o = lvl;

  wk_edge_detect #(.NPINS(NPINS)) u_edge (
    .clk_i, .rst_ni,
    .pins_i (pins_s),
    .mask_i (wake_mask_i),
    .rise_o (rise)
  );

  wk_fsm #(.NPINS(NPINS)) u_fsm (
    .clk_i, .rst_ni,
    .lvl_i      (lvl),
    .multi_en_i (multi_en_i),
    .rise_i     (rise),
    .wake_o     (wake_o)
  );
endmodule

// File: tb/tb_wake_detect.sv
module tb_wake_detect;
  localparam int FL = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       susp_en = 1'b0, multi_en = 1'b0, filt_en = 1'b0, susp = 1'b0;
  logic [7:0] mask = 8'h00, pins = 8'h00;
  logic       susp_lvl, wake;
  int         checks = 0, fails = 0, wake_cnt = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  wake_detect #(.NPINS(8), .FILT_LEN(FL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .susp_en_i(susp_en), .multi_en_i(multi_en),
    .filt_en_i(filt_en), .wake_mask_i(mask), .susp_i(susp), .wake_pins_i(pins),
    .susp_lvl_o(susp_lvl), .wake_o(wake)
  );

  always @(negedge clk) if (wake) wake_cnt++;

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_wakes(logic [7:0] m, int idx);
    return m[idx] ? 1 : 0;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; susp = 1'b0; pins = 8'h00;
    tick(2);
    rst_n = 1'b1;
    tick(1);
  endtask

  // put device asleep with bypass filter and let level settle
  task automatic go_sleep();
    susp = 1'b1;
    tick(FL + 4);
  endtask

  initial begin
    int w0;
    void'($urandom(32'h5eed_1234));
    tick(2);
    // R1
    chk(susp_lvl == 1'b0, "R1 lvl", susp_lvl, 0);
    chk(wake == 1'b0, "R1 wake", wake, 0);
    rst_n = 1'b1;
    tick(1);

    // R2: feature disabled
    w0 = wake_cnt;
    susp = 1'b1; tick(6);
    chk(susp_lvl == 1'b0, "R2 lvl", susp_lvl, 0);
    susp = 1'b0; tick(6);
    chk(wake_cnt == w0, "R2 wake", wake_cnt - w0, 0);

    // R3 latency, R5 single mode wake
    susp_en = 1'b1;
    susp = 1'b1; tick(1);
    chk(susp_lvl == 1'b0, "R3 early", susp_lvl, 0);
    tick(1);
    chk(susp_lvl == 1'b1, "R3 rise", susp_lvl, 1);
    tick(3);
    susp = 1'b0; tick(2);
    chk(susp_lvl == 1'b0 && wake == 1'b0, "R5 pre", wake, 0);
    tick(1);
    chk(wake == 1'b1, "R5 pulse", wake, 1);
    tick(1);
    chk(wake == 1'b0, "R11 width", wake, 0);

    // R4 filter latency and glitch rejection
    filt_en = 1'b1;
    susp = 1'b1; tick(FL + 1);
    chk(susp_lvl == 1'b0, "R4 early", susp_lvl, 0);
    tick(1);
    chk(susp_lvl == 1'b1, "R4 accept", susp_lvl, 1);
    tick(4);
    w0 = wake_cnt;
    susp = 1'b0; tick(FL - 1);
    susp = 1'b1; tick(FL + 6);
    chk(susp_lvl == 1'b1 && wake_cnt == w0, "R4 glitch", wake_cnt - w0, 0);
    susp = 1'b0; tick(FL + 4);
    chk(wake_cnt == w0 + 1, "R4 wake", wake_cnt - w0, 1);
    filt_en = 1'b0;

    // R6, R7, R9 (edge while high), R10
    multi_en = 1'b1; mask = 8'h0F;
    do_reset();
    go_sleep();
    w0 = wake_cnt;
    pins[2] = 1'b1; tick(6);
    chk(wake_cnt == w0, "R9 high", wake_cnt - w0, 0);
    susp = 1'b0; tick(6);
    chk(wake_cnt == w0, "R6/R10", wake_cnt - w0, 0);
    pins[4] = 1'b1; tick(6);
    chk(wake_cnt == w0, "R8", wake_cnt - w0, 0);
    pins[1] = 1'b1; tick(2);
    chk(wake == 1'b0, "R7 pre", wake, 0);
    tick(1);
    chk(wake == 1'b1, "R7 pulse", wake, 1);
    tick(1);
    chk(wake == 1'b0, "R11 multi", wake, 0);
    // awake now: further edges ignored
    pins = 8'h00; tick(3);
    w0 = wake_cnt;
    pins[0] = 1'b1; tick(6);
    chk(wake_cnt == w0, "R9 awake", wake_cnt - w0, 0);

    // R9: edge in the same cycle as the fall
    do_reset();
    go_sleep();
    w0 = wake_cnt;
    susp = 1'b0; pins[3] = 1'b1; tick(6);
    chk(wake_cnt == w0, "R9 same", wake_cnt - w0, 0);
    pins[3] = 1'b0; tick(3);
    pins[3] = 1'b1; tick(3);
    chk(wake == 1'b1, "R9 later", wake, 1);

    // random trials: R7/R8
    for (int t = 0; t < 40; t++) begin
      int idx;
      logic [7:0] m;
      m = 8'($urandom);
      if (t == 0) m = 8'hFF;
      if (t == 1) m = 8'h00;
      idx = int'($urandom_range(7, 0));
      mask = m;
      do_reset();
      go_sleep();
      susp = 1'b0; tick(5);
      w0 = wake_cnt;
      pins[idx] = 1'b1; tick(6);
      chk(wake_cnt - w0 == exp_wakes(m, idx), "R7/R8 random",
          wake_cnt - w0, exp_wakes(m, idx));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule